// File: doc/BRIEF.md
# Shared-Trial Multi-Key Search Engine

The engine locates a set of search values inside a power-of-two key space in one combined pass rather than in one pass per value. A single trial register walks the key space under control of a one-hot step register. Shifting the step right halves the region under test. Shifting it left grows the region back towards larger keys. When a grown region turns out to hold pending values, the engine saves where it stands as a resume point. It then narrows down inside that region and resumes from the saved point once every value captured there has been found. Every trial point is compared in parallel against all values that are still outstanding.

A user presents all values on a flat bus and pulses `start`. The engine latches them and runs without further input. It raises `done` when every value has been located. For each value it reports a found flag and the key at which that value was met. It also reports how many comparison cycles the pass took, which shows how much the shared walk saves when values sit close together.

Top module: `ibs_engine`

## Requirements
- R1: After reset `done_o` is 0, every bit of `found_o` is 0 and `trials_o` is 0.
- R2: A `start` pulse while the engine is idle or finished latches `items_i` and clears `found_o`, `trials_o` and `done_o` at that clock edge. The first comparison is made in the next cycle.
- R3: A `start` pulse while a search is running has no effect. The latched values, and hence the reported keys, stay those of the accepted start.
- R4: Every value is eventually found, and its key on `keys_o` (slot k in bits k*KEY_W+KEY_W-1 down to k*KEY_W) equals the value given in slot k of `items_i`.
- R5: Values that are equal are found in the same cycle and report the same key.
- R6: `done_o` rises only when all bits of `found_o` are 1. It then stays 1, with found flags and keys unchanged, until the next accepted `start`.
- R7: `trials_o` grows by exactly one per comparison cycle. When all slots hold one value v other than 0, the search ends after KEY_W minus (number of trailing zero bits of v) comparisons.
- R8: A value of 0 is resolved at the close of the first, narrowing, phase without a comparison of its own and reports key 0. When all slots hold 0, the search takes exactly KEY_W comparisons.
- R9: Once a found flag is set, that flag and its key do not change until the next accepted `start`.
- R10: With a 4-bit key space, the values 3, 5, 3 are found after 6 comparisons: four in the narrowing phase, one at the grown point 7 that opens a resume point, and one inside the narrowed region at 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search with the values on `items_i` |
| items_i | input | ITEMS*KEY_W | Search values, slot k in bits k*KEY_W upward |
| found_o | output | ITEMS | Per-slot found flag |
| keys_o | output | ITEMS*KEY_W | Per-slot key at which the value was met |
| trials_o | output | TRIAL_W | Number of comparison cycles in the current search |
| done_o | output | 1 | All values located |

## Verification
The hardest state to reach is a resume point being restored after a nested narrowing. This needs one value that is found early, plus a later value that lies inside a grown region and is not on the narrowing path. A further value must lie above that region. The bench gets there by sweeping every pair of 4-bit values in two slots with a third slot derived from them, which covers nested and back-to-back resume points. It also repeats a single value in all slots, which pins the exact comparison count of the narrowing phase and the zero case.

// File: rtl/ibs_pkg.sv
package ibs_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_NARROW,
      S_GROW_STEP,
      S_GROW_EVAL,
      S_SPLIT_STEP,
      S_SPLIT_EVAL,
      S_DONE
   } ibs_state_e;
endpackage

// File: rtl/ibs_lane.sv
module ibs_lane #(
   parameter int KEY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [KEY_W-1:0] item_in,
   input  logic [KEY_W-1:0] ad,
   input  logic             eval,
   input  logic             zero_res,
   input  logic             mark_p,
   output logic             found_o,
   output logic             found_nx_o,
   output logic             low_o,
   output logic             p_keep_o,
   output logic [KEY_W-1:0] key_o
);
   logic [KEY_W-1:0] item_q;
   logic [KEY_W-1:0] key_q;
   logic             found_q;
   logic             pm_q;
   logic             eq;

   assign eq         = !found_q && (item_q == ad);
   assign low_o      = !found_q && (item_q < ad);
   assign p_keep_o   = pm_q && !(eval && eq);
   assign found_nx_o = found_q || (eval && eq) || (zero_res && low_o);
   assign found_o    = found_q;
   assign key_o      = key_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         item_q  <= '0;
         key_q   <= '0;
         found_q <= 1'b0;
         pm_q    <= 1'b0;
      end else if (load) begin
         item_q  <= item_in;
         key_q   <= '0;
         found_q <= 1'b0;
         pm_q    <= 1'b0;
      end else if (eval && eq) begin
         found_q <= 1'b1;
         key_q   <= ad;
         pm_q    <= 1'b0;
      end else if (zero_res && low_o) begin
         found_q <= 1'b1;
         key_q   <= '0;
         pm_q    <= 1'b0;
      end else if (mark_p && low_o) begin
         pm_q    <= 1'b1;
      end
   end

   a_r3_item_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(item_q));
   a_r9_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (found_q && !load) |=> (found_q && $stable(key_q)));
   a_r9_mark_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !(pm_q && found_q));
endmodule

// File: rtl/ibs_trial_cnt.sv
module ibs_trial_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + W'(1);
   end

   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (count == $past(count) + W'(1)));
   a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/ibs_engine.sv
module ibs_engine
   import ibs_pkg::*;
#(
   parameter int KEY_W   = 8,
   parameter int ITEMS   = 4,
   parameter int TRIAL_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [ITEMS*KEY_W-1:0]   items_i,
   output logic [ITEMS-1:0]         found_o,
   output logic [ITEMS*KEY_W-1:0]   keys_o,
   output logic [TRIAL_W-1:0]       trials_o,
   output logic                     done_o
);
   localparam logic [KEY_W-1:0] TOP_BIT = KEY_W'(1) << (KEY_W - 1);

   initial begin
      assert (KEY_W >= 2) else $error("KEY_W must be at least 2");
      assert (ITEMS >= 1) else $error("ITEMS must be at least 1");
      assert (TRIAL_W >= 4) else $error("TRIAL_W must be at least 4");
   end

   ibs_state_e       state;
   logic [KEY_W-1:0] ad, x, adc, xc, x_up, x_dn;
   logic             cop_pend;
   logic             busy, accept, eval, zero_res;
   logic             any_low, p_any, all_found_nx, restore_now, create_cop;
   logic [ITEMS-1:0] low_v, found_nx_v, p_keep_v;

   assign busy     = (state != S_IDLE) && (state != S_DONE);
   assign accept   = start && !busy;
   assign eval     = (state == S_NARROW) || (state == S_GROW_EVAL) || (state == S_SPLIT_EVAL);
   assign zero_res = (state == S_NARROW) && x[0];
   assign x_up     = x << 1;
   assign x_dn     = x >> 1;

   assign any_low      = |low_v;
   assign p_any        = |p_keep_v;
   assign all_found_nx = &found_nx_v;
   assign restore_now  = cop_pend && !p_any && (adc >= ad);
   assign create_cop   = (state == S_GROW_EVAL) && !restore_now && any_low && !p_any && !cop_pend;

   for (genvar k = 0; k < ITEMS; k++) begin : g_lane
      ibs_lane #(.KEY_W(KEY_W)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (accept),
         .item_in    (items_i[k*KEY_W +: KEY_W]),
         .ad         (ad),
         .eval       (eval),
         .zero_res   (zero_res),
         .mark_p     (create_cop),
         .found_o    (found_o[k]),
         .found_nx_o (found_nx_v[k]),
         .low_o      (low_v[k]),
         .p_keep_o   (p_keep_v[k]),
         .key_o      (keys_o[k*KEY_W +: KEY_W])
      );
   end

   ibs_trial_cnt #(.W(TRIAL_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (eval),
      .count (trials_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         ad       <= '0;
         x        <= '0;
         adc      <= '0;
         xc       <= '0;
         cop_pend <= 1'b0;
      end else if (accept) begin
         state    <= S_NARROW;
         ad       <= TOP_BIT;
         x        <= TOP_BIT;
         cop_pend <= 1'b0;
      end else begin
         unique case (state)
            S_NARROW: begin
               if (all_found_nx) begin
                  state <= S_DONE;
               end else if (x[0]) begin
                  ad    <= any_low ? (ad & ~x) : ad;
                  state <= S_GROW_STEP;
               end else begin
                  ad <= (any_low ? (ad & ~x) : ad) | x_dn;
                  x  <= x_dn;
               end
            end
            S_GROW_STEP: begin
               if ((ad & x) != '0) begin
                  x <= x_up;
               end else begin
                  ad    <= ad | x;
                  state <= S_GROW_EVAL;
               end
            end
            S_GROW_EVAL: begin
               if (all_found_nx) begin
                  state <= S_DONE;
               end else if (restore_now) begin
                  ad       <= adc;
                  x        <= xc;
                  cop_pend <= 1'b0;
               end else if (any_low) begin
                  if (create_cop) begin
                     cop_pend <= 1'b1;
                     xc       <= (x_up == '0) ? x : x_up;
                     adc      <= ad | x_up;
                  end
                  state <= S_SPLIT_STEP;
               end else begin
                  state <= S_GROW_STEP;
               end
            end
            S_SPLIT_STEP: begin
               if (!p_any) begin
                  if (cop_pend) begin
                     ad       <= adc;
                     x        <= xc;
                     cop_pend <= 1'b0;
                     state    <= S_GROW_EVAL;
                  end else begin
                     state <= S_GROW_STEP;
                  end
               end else if (x[0]) begin
                  state <= S_GROW_STEP;
               end else begin
                  x     <= x_dn;
                  ad    <= ad & ~x_dn;
                  state <= S_SPLIT_EVAL;
               end
            end
            S_SPLIT_EVAL: begin
               if (all_found_nx) begin
                  state <= S_DONE;
               end else begin
                  if (!any_low && p_any) ad <= ad | x;
                  state <= S_SPLIT_STEP;
               end
            end
            default: ;
         endcase
      end
   end

   assign done_o = (state == S_DONE);

   a_r6_done_all: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (&found_o));
   a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start) |=> done_o);
   a_r7_step_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $onehot(x));
   a_r3_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (state != S_IDLE));
   a_r2_accept_clear: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (found_o == '0 && trials_o == '0 && !done_o));
endmodule

// File: tb/tb_ibs_engine.sv
module tb_ibs_engine;
   localparam int Q  = 4;
   localparam int N  = 3;
   localparam int TW = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [N*Q-1:0]  items_i = '0;
   logic [N-1:0]    found_o;
   logic [N*Q-1:0]  keys_o;
   logic [TW-1:0]   trials_o;
   logic            done_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   ibs_engine #(.KEY_W(Q), .ITEMS(N), .TRIAL_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .items_i(items_i),
      .found_o(found_o), .keys_o(keys_o), .trials_o(trials_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int tz(input int v);
      int n = 0;
      for (int b = 0; b < Q; b++) begin
         if (((v >> b) & 1) != 0) return n;
         n++;
      end
      return Q;
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "watchdog", cycles, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // Run one search; returns number of comparisons reported
   task automatic run(input int a, input int b, input int c, input bit poke, output int tr);
      int wait_n = 0;
      @(negedge clk);
      items_i = {Q'(c), Q'(b), Q'(a)};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: cleared at the accepting edge
      check(!done_o && found_o == '0 && trials_o == '0, "R2", int'(trials_o), 0);
      if (poke) begin
         items_i = {Q'(a ^ 9), Q'(b ^ 6), Q'(c ^ 15)};
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done_o && wait_n < 300) begin
         @(negedge clk);
         wait_n++;
      end
      check(done_o, "R6 done", int'(done_o), 1);
      check(found_o == '1, "R6 found", int'(found_o), (1 << N) - 1);
      check(int'(keys_o[0 +: Q]) == a, "R4 key0", int'(keys_o[0 +: Q]), a);
      check(int'(keys_o[Q +: Q]) == b, "R4 key1", int'(keys_o[Q +: Q]), b);
      check(int'(keys_o[2*Q +: Q]) == c, "R4 key2", int'(keys_o[2*Q +: Q]), c);
      tr = int'(trials_o);
   endtask

   initial begin
      int tr;
      logic [N*Q-1:0] kept;
      // R1: reset state
      #3;
      check(!done_o && found_o == '0 && trials_o == '0, "R1", int'(found_o), 0);
      #20 rst_n = 1'b1;
      @(negedge clk);
      check(!done_o && trials_o == '0, "R1 idle", int'(trials_o), 0);

      // R10: directed resume-point case
      run(3, 5, 3, 1'b0, tr);
      check(tr == 6, "R10", tr, 6);

      // R6 / R9: outputs hold after completion
      kept = keys_o;
      repeat (4) @(negedge clk);
      check(done_o && found_o == '1, "R6 hold", int'(done_o), 1);
      check(keys_o == kept, "R9 keys stable", int'(keys_o), int'(kept));

      // R7 / R8 / R5: one value in every slot
      for (int v = 0; v < (1 << Q); v++) begin
         int exp_t;
         run(v, v, v, 1'b0, tr);
         exp_t = (v == 0) ? Q : Q - tz(v);
         if (v == 0) check(tr == exp_t, "R8 zero", tr, exp_t);
         else        check(tr == exp_t, "R7 single", tr, exp_t);
         check(keys_o[0 +: Q] == keys_o[Q +: Q] && keys_o[Q +: Q] == keys_o[2*Q +: Q],
               "R5 equal keys", int'(keys_o[Q +: Q]), v);
      end

      // R3: start during a search is ignored
      run(12, 1, 7, 1'b1, tr);
      run(0, 15, 8, 1'b1, tr);

      // R4: sweep of two slots, third derived
      for (int i = 0; i < (1 << Q); i++) begin
         for (int j = 0; j < (1 << Q); j++) begin
            run(i, j, (i * 5 + j * 3) % (1 << Q), 1'b0, tr);
            check(tr >= 1 && tr <= 40, "R7 bound", tr, 40);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule